// File: doc/BRIEF.md
# Unsigned Wide-Dividend Divider

This block divides a 32-bit unsigned dividend, given as a high word and a low word, by a 16-bit unsigned divisor. It returns a 16-bit quotient, a 16-bit remainder and an overflow flag. A caller pulses `start_i` while the block is idle and then waits for the one-cycle `done_o` pulse. The results stay on the outputs until the next operation finishes.

Overflow is decided before any iteration begins. The divisor is compared with the dividend's high word. The quotient fits in 16 bits exactly when the divisor is strictly larger than that word. An unsigned compare of the whole words gives the right answer even when both operands have their top bit set. When overflow is flagged, the block skips the iterations and returns a saturated quotient of FFFFh. When there is no overflow, a restoring shift-subtract datapath produces one quotient bit per clock.

Top module: `divu_wide`

## Requirements
- R1: When no overflow is flagged, `quot_o` equals floor({hi,lo} / divisor) when `done_o` is high.
- R2: When no overflow is flagged, `rem_o` equals {hi,lo} mod divisor, which is strictly less than the divisor.
- R3: `ovf_o` is 1 exactly when the divisor is less than or equal to the dividend high word, and 0 when the divisor is strictly greater.
- R4: When `ovf_o` is 1, `quot_o` is FFFFh. The value of `rem_o` is unspecified in that case.
- R5: Operands whose high word and divisor both have bit 15 set are flagged as overflow whenever the divisor does not exceed the high word. Examples: F0F0_0F0Fh / F0F0h, 8080_0808h / 8080h, 8008_0880h / 8008h, 8000_0008h / 8000h and F0FF_0FFFh / F0FFh.
- R6: A zero divisor is an overflow. The block sets `ovf_o`, returns FFFFh as the quotient and runs no iterations.
- R7: The clock edge that accepts `start_i` is counted as edge 0. A divide without overflow raises `done_o` after edge 17, which is one setup cycle plus 16 iterations. An overflowed divide raises `done_o` after edge 1.
- R8: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after acceptance until `done_o` rises, and it is low while `done_o` is high.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running divide finishes with its own operands and timing, and no extra `done_o` pulse follows.
- R10: After reset, `busy_o`, `done_o` and `ovf_o` are 0, and `quot_o` and `rem_o` are 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| dvd_hi_i | input | 16 | Dividend high word |
| dvd_lo_i | input | 16 | Dividend low word |
| dvsr_i | input | 16 | Divisor |
| busy_o | output | 1 | A divide is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 16 | Quotient, or FFFFh on overflow |
| rem_o | output | 16 | Remainder, valid when no overflow |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench targets operand pairs where both the divisor and the dividend high word have bit 15 set. A design that judged overflow only on the low part of the comparison, or on a truncated partial remainder, would clear the flag there and return a wrapped quotient such as FFFFh with `ovf_o` low. It also covers the boundary where the divisor is exactly one more than the high word and the divisor is FFFFh. In that case the 17-bit trial value during iteration must not be truncated, or the quotient and remainder come out wrong. Zero divisors, a start pulse issued mid-divide and exact latency counts round this out. A design that iterated on overflow, restarted on a second start, or miscounted iterations would show a wrong quotient or a late or extra `done_o`.

// File: rtl/divu_pkg.sv
// divu_pkg: shared types for the wide-dividend divider.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package divu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2
    } divu_state_e;
endpackage

// File: rtl/divu_ovf_check.sv
// divu_ovf_check: decides before iteration whether the quotient can fit.
// The quotient fits in W bits only if the divisor is strictly greater than
// the dividend high word; a zero divisor always lands on the overflow side.
// Assumes: both inputs are unsigned.
module divu_ovf_check #(
    parameter int W = 16
) (
    input  logic [W-1:0] hi_word,
    input  logic [W-1:0] divisor,
    output logic         ovf
);
    // full-width unsigned compare, valid for any top-bit combination
    always_comb begin
        ovf = (divisor <= hi_word);
    end
endmodule

// File: rtl/divu_step.sv
// divu_step: one restoring shift-subtract step producing one quotient bit.
// The partial remainder is shifted left with the next dividend bit, giving a
// W+1 bit trial value; if it is not below the divisor the divisor is taken
// off and a 1 enters the quotient.
// Assumes: part < divisor on entry (guaranteed when no overflow was flagged).
module divu_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] part,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] part_n,
    output logic [W-1:0] lo_n
);
    localparam int TW = W + 1;

    logic [TW-1:0] trial;
    logic [TW-1:0] diff;
    logic          fits;

    // build trial value, compare and conditionally subtract
    always_comb begin
        trial  = {part, lo[W-1]};
        diff   = trial - {1'b0, divisor};
        fits   = (trial >= {1'b0, divisor});
        part_n = fits ? diff[W-1:0] : trial[W-1:0];
        lo_n   = {lo[W-2:0], fits};
    end
endmodule

// File: rtl/divu_ctrl.sv
// divu_ctrl: sequencer for the divider. Accepts a start only when idle,
// spends one cycle on the overflow decision, then runs W iteration cycles.
// Emits one-cycle strobes for loading operands, iterating and finishing.
// Assumes: ovf_now is valid in the check state (driven from captured operands).
module divu_ctrl
    import divu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ovf_now,
    output logic load,
    output logic iter_en,
    output logic fin_ovf,
    output logic fin_ok,
    output logic busy
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    divu_state_e   state_q;
    logic [CW-1:0] cnt_q;

    // decode strobes from the current state
    always_comb begin
        load    = (state_q == ST_IDLE) && start;
        iter_en = (state_q == ST_RUN);
        fin_ovf = (state_q == ST_CHECK) && ovf_now;
        fin_ok  = (state_q == ST_RUN) && (cnt_q == LAST);
        busy    = (state_q != ST_IDLE);
    end

    // state and iteration counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    cnt_q   <= '0;
                    state_q <= ovf_now ? ST_IDLE : ST_RUN;
                end
                ST_RUN: begin
                    if (cnt_q == LAST) state_q <= ST_IDLE;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: a new operation can only begin from idle
    a_r9_check_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_CHECK));

    // R7: iterations always begin at count zero
    a_r7_run_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !ovf_now) |=> (state_q == ST_RUN && cnt_q == '0));

    // R6: an overflowed check never enters iteration
    a_r6_no_run_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && ovf_now) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/divu_wide.sv
// divu_wide: unsigned 2W-by-W divider, one quotient bit per clock.
// Captures operands on an accepted start, decides overflow from the captured
// high word and divisor, then iterates. Results are registered and held
// until the next operation completes. Overflow returns an all-ones quotient.
// Assumes: synchronous active-low reset; start is ignored while busy.
module divu_wide #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dvd_hi_i,
    input  logic [W-1:0] dvd_lo_i,
    input  logic [W-1:0] dvsr_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         ovf_o
);
    logic [W-1:0] part_q, lo_q, div_q;
    logic [W-1:0] part_n, lo_n;
    logic         ovf_now, load, iter_en, fin_ovf, fin_ok, busy;
    logic [W-1:0] quot_q, rem_q;
    logic         ovf_q, done_q;

    divu_ovf_check #(.W(W)) u_ovf (
        .hi_word (part_q),
        .divisor (div_q),
        .ovf     (ovf_now)
    );

    divu_step #(.W(W)) u_step (
        .part    (part_q),
        .lo      (lo_q),
        .divisor (div_q),
        .part_n  (part_n),
        .lo_n    (lo_n)
    );

    divu_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .ovf_now (ovf_now),
        .load    (load),
        .iter_en (iter_en),
        .fin_ovf (fin_ovf),
        .fin_ok  (fin_ok),
        .busy    (busy)
    );

    // working registers: capture operands, then shift-subtract
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            lo_q   <= '0;
            div_q  <= '0;
        end else if (load) begin
            part_q <= dvd_hi_i;
            lo_q   <= dvd_lo_i;
            div_q  <= dvsr_i;
        end else if (iter_en) begin
            part_q <= part_n;
            lo_q   <= lo_n;
        end
    end

    // result registers and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
            ovf_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin_ovf | fin_ok;
            if (fin_ovf) begin
                quot_q <= '1;
                rem_q  <= part_q;
                ovf_q  <= 1'b1;
            end else if (fin_ok) begin
                quot_q <= lo_n;
                rem_q  <= part_n;
                ovf_q  <= 1'b0;
            end
        end
    end

    assign busy_o = busy;
    assign done_o = done_q;
    assign quot_o = quot_q;
    assign rem_o  = rem_q;
    assign ovf_o  = ovf_q;

    // R8: completion is a single-cycle pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: not busy while reporting completion
    a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4: overflow always reports a saturated quotient
    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (quot_o == '1));

    // R2: a valid remainder is below the divisor used
    a_r2_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o) |-> (rem_o < div_q));

    // R3: no-overflow completion only after a full run
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ovf_o) |-> $past(iter_en));
endmodule

// File: tb/divu_wide_test.sv
module divu_wide_test;
    localparam int  W     = 16;
    localparam time T_CLK = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] dvd_hi_i = '0, dvd_lo_i = '0, dvsr_i = '0;
    logic         busy_o, done_o, ovf_o;
    logic [W-1:0] quot_o, rem_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    divu_wide #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvsr_i(dvsr_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
        .rem_o(rem_o), .ovf_o(ovf_o)
    );

    always #(T_CLK/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // launch one divide, measure latency, compare with 64-bit model
    task automatic run_div(input logic [W-1:0] hi, input logic [W-1:0] lo,
                           input logic [W-1:0] d, input string tag);
        logic [63:0] dvd, q, r;
        bit          exp_ovf;
        int          n;
        dvd = {32'd0, hi, lo};
        exp_ovf = (d == 0) || (d <= hi);
        q = exp_ovf ? 64'hFFFF : dvd / {48'd0, d};
        r = exp_ovf ? 64'd0 : dvd % {48'd0, d};
        @(negedge clk);
        dvd_hi_i = hi; dvd_lo_i = lo; dvsr_i = d; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        check(busy_o == 1'b1, "R8 busy after accept", longint'(busy_o), 1);
        while (!done_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(n == (exp_ovf ? 1 : 17), {"R7 latency ", tag}, n, exp_ovf ? 1 : 17);
        check(ovf_o == exp_ovf, {"R3 ovf ", tag}, longint'(ovf_o), longint'(exp_ovf));
        if (exp_ovf)
            check(quot_o == 16'hFFFF, {"R4 saturate ", tag}, longint'(quot_o), 64'hFFFF);
        else begin
            check(quot_o == q[15:0], {"R1 quot ", tag}, longint'(quot_o), longint'(q));
            check(rem_o == r[15:0], {"R2 rem ", tag}, longint'(rem_o), longint'(r));
        end
        check(busy_o == 1'b0, "R8 idle at done", longint'(busy_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done single", longint'(done_o), 0);
    endtask

    task automatic t_reset();
        check(busy_o == 0 && done_o == 0 && ovf_o == 0, "R10 reset flags",
              longint'({busy_o, done_o, ovf_o}), 0);
        check(quot_o == 0 && rem_o == 0, "R10 reset data",
              longint'({quot_o, rem_o}), 0);
    endtask

    task automatic t_basic();
        run_div(16'h0000, 16'h0064, 16'h0007, "100/7");
        run_div(16'h0000, 16'hBEEF, 16'h0001, "div by one");
        run_div(16'h0001, 16'h0000, 16'h0002, "10000h/2");
        run_div(16'h1234, 16'h5678, 16'h9ABC, "mid");
    endtask

    task automatic t_top_bits();   // R5 corner patterns
        run_div(16'hF0F0, 16'h0F0F, 16'hF0F0, "R5 F0F0");
        run_div(16'h8080, 16'h0808, 16'h8080, "R5 n0n0");
        run_div(16'h8008, 16'h0880, 16'h8008, "R5 n00n");
        run_div(16'h8000, 16'h0008, 16'h8000, "R5 n000");
        run_div(16'hF0FF, 16'h0FFF, 16'hF0FF, "R5 n0nn");
        run_div(16'hFFFF, 16'hFFFF, 16'hFFFF, "R5 all ones");
        run_div(16'hC000, 16'h0000, 16'h8000, "R5 hi above div");
    endtask

    task automatic t_boundary();
        run_div(16'hFFFE, 16'hFFFF, 16'hFFFF, "max no ovf");
        run_div(16'h7FFF, 16'hFFFF, 16'h8000, "hi=div-1");
        run_div(16'h8000, 16'h0000, 16'h8000, "hi=div");
        run_div(16'h0000, 16'h0000, 16'h0000, "R6 zero div zero");
        run_div(16'h1234, 16'h5678, 16'h0000, "R6 zero div");
    endtask

    task automatic t_start_busy();  // R9
        int n;
        @(negedge clk);
        dvd_hi_i = 16'h0000; dvd_lo_i = 16'h03E8; dvsr_i = 16'h000A; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        repeat (4) begin @(negedge clk); n++; end
        dvd_hi_i = 16'hFFFF; dvd_lo_i = 16'h0000; dvsr_i = 16'h0001; start_i = 1'b1;
        @(negedge clk); n++;
        start_i = 1'b0;
        while (!done_o && n < 40) begin @(negedge clk); n++; end
        check(n == 17, "R9 latency kept", n, 17);
        check(quot_o == 16'd100 && ovf_o == 0, "R9 operands kept",
              longint'(quot_o), 100);
        n = 0;
        repeat (25) begin @(negedge clk); if (done_o || busy_o) n++; end
        check(n == 0, "R9 no extra done", n, 0);
    endtask

    task automatic t_random();
        logic [W-1:0] hi, lo, d;
        for (int i = 0; i < 150; i++) begin
            d  = W'($urandom);
            lo = W'($urandom);
            if (i % 3 == 0 || d == 0) hi = W'($urandom);
            else hi = W'($urandom % d);
            run_div(hi, lo, d, "random");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_top_bits();
        t_boundary();
        t_start_busy();
        t_random();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule